// File: doc/BRIEF.md
# Dual-Port Register Address Pointer

This block sits between a serial host's protocol engine and the register file of a two-port GPIO expander. The host first sends an 8-bit register address and then a run of data bytes. The block holds that address as a pointer and decodes it into a register index and a port select, so the register storage knows which cell each byte touches. After every data byte it moves the pointer to the next address.

Two register layouts are supported, chosen by a layout bit. In separated layout, the eleven port-A registers sit in one block and the port-B copies sit in a second block. In paired layout, the A and B copies of each register are interleaved as even/odd neighbours. A second bit chooses between auto-increment and the non-incrementing mode. In paired layout the non-incrementing mode alternates between the two halves of a pair. The serial protocol engine and the register cells are outside this block.

Register index encoding (used by both layouts): 0 direction, 1 input inversion, 2 change-interrupt enable, 3 compare reference, 4 compare select, 5 shared configuration, 6 pull-up, 7 interrupt flag, 8 capture, 9 pin level, 10 output latch.

Top module: `regptr_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ptr` is 00h, `addr_valid` is 1, `reg_idx` is 0 and `port_b` is 0.
- R2: With `bank_sep`=1, addresses 00h–0Ah decode to `reg_idx` equal to the address with `port_b`=0, and addresses 10h–1Ah decode to `reg_idx` equal to the address minus 10h with `port_b`=1.
- R3: With `bank_sep`=0, addresses 00h–15h decode to `reg_idx` equal to the address shifted right by one, and `port_b` equal to the address LSB.
- R4: The shared configuration register (index 5) is reached at 05h and 15h in separated layout, and at both 0Ah and 0Bh in paired layout.
- R5: `addr_valid` is 0 for 0Bh–0Fh and above 1Ah in separated layout, and above 15h in paired layout. While `addr_valid` is 0, `reg_idx` and `port_b` read 0.
- R6: With `bank_sep`=1 and `incr_en`=1, a byte strobe adds one to the pointer, except that 0Ah steps to 10h and any pointer at or above 1Ah steps to 00h.
- R7: With `bank_sep`=0 and `incr_en`=1, a byte strobe adds one to the pointer, except that any pointer at or above 15h steps to 00h.
- R8: With `bank_sep`=1 and `incr_en`=0, a byte strobe leaves the pointer unchanged.
- R9: With `bank_sep`=0 and `incr_en`=0, a byte strobe inverts the pointer LSB, whichever half of the pair was loaded.
- R10: A load strobe sets `ptr` to `load_addr` on the next cycle. This holds even when a byte strobe comes in the same cycle.
- R11: The pointer moves only on a strobe. The next-address rule uses the `bank_sep` and `incr_en` values present at that byte strobe. The decode always follows the current `bank_sep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_stb | input | 1 | Load the pointer from `load_addr` |
| load_addr | input | 8 | Register address sent by the host |
| byte_stb | input | 1 | One data byte has completed |
| bank_sep | input | 1 | 1 = separated layout, 0 = paired layout |
| incr_en | input | 1 | 1 = auto-increment, 0 = hold or alternate |
| ptr | output | 8 | Current pointer |
| reg_idx | output | 4 | Decoded register index |
| port_b | output | 1 | 1 when the pointer addresses a port-B copy |
| addr_valid | output | 1 | Pointer lies inside the active map |

## Verification
Directed runs cover the cases where the two layouts disagree:
- In separated layout, a burst starting at 09h shows the gap skip.
- Bursts at 1Ah and 15h show the two wrap points.
- Non-incrementing runs loaded on both the even and the odd half of a pair show that paired layout alternates while separated layout holds.

A same-cycle load and byte strobe shows the load wins. A layout change with no strobe shows that only the decode moves, not the pointer. Random strobes, addresses and mode bits then compare every field against the bench's own model on every cycle. This reaches the invalid holes and the out-of-map addresses above the wrap points.

// File: rtl/regptr_pkg.sv
package regptr_pkg;

    localparam int ADDR_W  = 8;
    localparam int IDX_W   = 4;
    localparam int NREG    = 11;
    localparam logic [ADDR_W-1:0] SEP_A_LAST = ADDR_W'(NREG - 1);
    localparam logic [ADDR_W-1:0] SEP_B_BASE = 8'h10;
    localparam logic [ADDR_W-1:0] SEP_B_LAST = SEP_B_BASE + SEP_A_LAST;
    localparam logic [ADDR_W-1:0] PAIR_LAST  = ADDR_W'(2 * NREG - 1);

    typedef enum logic [IDX_W-1:0] {
        R_DIR, R_INV, R_CHG_EN, R_REF, R_CMP_SEL, R_CFG,
        R_PULL, R_FLAG, R_SNAP, R_PIN, R_LATCH
    } reg_kind_t;

    typedef enum logic {LAYOUT_PAIR = 1'b0, LAYOUT_SEP = 1'b1} layout_t;

    typedef struct packed {
        logic      valid;
        reg_kind_t kind;
        logic      port_b;
    } slot_t;

    typedef struct packed {
        layout_t layout;
        logic    incr;
    } mode_t;

endpackage

// File: rtl/regptr_decode.sv
module regptr_decode
    import regptr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  layout_t           layout,
    output slot_t             slot
);
    logic [3:0] hi_nib;
    logic [3:0] lo_nib;

    assign hi_nib = addr[7:4];
    assign lo_nib = addr[3:0];

    always_comb begin
        slot = '{valid: 1'b0, kind: R_DIR, port_b: 1'b0};
        if (layout == LAYOUT_SEP) begin
            if (hi_nib <= 4'd1 && {4'd0, lo_nib} <= SEP_A_LAST) begin
                slot.valid  = 1'b1;
                slot.kind   = reg_kind_t'(lo_nib);
                slot.port_b = hi_nib[0];
            end
        end else begin
            if (addr <= PAIR_LAST) begin
                slot.valid  = 1'b1;
                slot.kind   = reg_kind_t'(addr[IDX_W:1]);
                slot.port_b = addr[0];
            end
        end
    end
endmodule

// File: rtl/regptr_step.sv
module regptr_step
    import regptr_pkg::*;
(
    input  logic [ADDR_W-1:0] cur,
    input  mode_t             mode,
    output logic [ADDR_W-1:0] nxt
);
    always_comb begin
        if (!mode.incr) begin
            nxt = (mode.layout == LAYOUT_SEP) ? cur : {cur[ADDR_W-1:1], ~cur[0]};
        end else if (mode.layout == LAYOUT_SEP) begin
            if (cur == SEP_A_LAST)
                nxt = SEP_B_BASE;
            else if (cur >= SEP_B_LAST)
                nxt = '0;
            else
                nxt = cur + 1'b1;
        end else begin
            nxt = (cur >= PAIR_LAST) ? '0 : cur + 1'b1;
        end
    end
endmodule

// File: rtl/regptr_top.sv
module regptr_top
    import regptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_stb,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              byte_stb,
    input  logic              bank_sep,
    input  logic              incr_en,
    output logic [ADDR_W-1:0] ptr,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              port_b,
    output logic              addr_valid
);
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_step;
    mode_t             mode_now;
    slot_t             slot;

    assign mode_now = '{layout: layout_t'(bank_sep), incr: incr_en};

    regptr_step u_step (
        .cur  (ptr_q),
        .mode (mode_now),
        .nxt  (ptr_step)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (load_stb)
            ptr_q <= load_addr;
        else if (byte_stb)
            ptr_q <= ptr_step;
    end

    regptr_decode u_dec (
        .addr   (ptr_q),
        .layout (mode_now.layout),
        .slot   (slot)
    );

    assign ptr        = ptr_q;
    assign reg_idx    = slot.kind;
    assign port_b     = slot.port_b;
    assign addr_valid = slot.valid;
endmodule

// File: rtl/regptr_chk.sv
module regptr_chk
    import regptr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load_stb,
    input logic [ADDR_W-1:0] load_addr,
    input logic              byte_stb,
    input logic              bank_sep,
    input logic              incr_en,
    input logic [ADDR_W-1:0] ptr,
    input logic [IDX_W-1:0]  reg_idx,
    input logic              port_b,
    input logic              addr_valid
);
    // R10
    load_prio_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> ptr == $past(load_addr));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_stb && !byte_stb) |=> $stable(ptr));

    // R8
    sep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_stb && !load_stb && bank_sep && !incr_en) |=> $stable(ptr));

    // R9
    pair_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_stb && !load_stb && !bank_sep && !incr_en) |=> ptr == ($past(ptr) ^ 8'h01));

    // R6
    gap_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_stb && !load_stb && bank_sep && incr_en && ptr == 8'h0A) |=> ptr == 8'h10);

    // R7
    pair_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_stb && !load_stb && !bank_sep && incr_en && ptr == 8'h15) |=> ptr == 8'h00);

    // R5
    pair_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!bank_sep && addr_valid) |-> ptr <= 8'h15);

    // R5
    invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |-> (reg_idx == 4'd0 && !port_b));
endmodule

bind regptr_top regptr_chk u_chk (.*);

// File: tb/tb_regptr_top.sv
`timescale 1ns/1ps
module tb_regptr_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       load_stb, byte_stb, bank_sep, incr_en;
    logic [7:0] load_addr;
    logic [7:0] ptr;
    logic [3:0] reg_idx;
    logic       port_b, addr_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] exp_ptr;

    always #2 clk = ~clk;

    regptr_top dut (.*);

    function automatic logic [7:0] m_next(logic [7:0] p, logic sep, logic inc);
        if (!inc) return sep ? p : (p ^ 8'h01);
        if (sep) begin
            if (p == 8'h0A) return 8'h10;
            if (p >= 8'h1A) return 8'h00;
            return p + 8'd1;
        end
        if (p >= 8'h15) return 8'h00;
        return p + 8'd1;
    endfunction

    function automatic logic [5:0] m_dec(logic [7:0] p, logic sep);
        logic v; logic [3:0] i; logic b;
        if (sep) begin
            v = (p <= 8'h0A) || (p >= 8'h10 && p <= 8'h1A);
            i = 4'(p - (p >= 8'h10 ? 8'h10 : 8'h00));
            b = (p >= 8'h10);
        end else begin
            v = (p <= 8'h15);
            i = 4'(p >> 1);
            b = p[0];
        end
        if (!v) begin i = 0; b = 0; end
        return {v, i, b};
    endfunction

    task automatic check(string req);
        logic [5:0] e;
        e = m_dec(exp_ptr, bank_sep);
        checks++;
        if (ptr !== exp_ptr || {addr_valid, reg_idx, port_b} !== e) begin
            fails++;
            $display("FAIL %s: ptr=%h valid=%b idx=%0d b=%b expected ptr=%h valid=%b idx=%0d b=%b",
                     req, ptr, addr_valid, reg_idx, port_b, exp_ptr, e[5], e[4:1], e[0]);
        end
    endtask

    task automatic tick(logic ld, logic [7:0] a, logic by, logic sep, logic inc, string req);
        @(negedge clk);
        load_stb = ld; load_addr = a; byte_stb = by; bank_sep = sep; incr_en = inc;
        @(posedge clk);
        if (ld) exp_ptr = a;
        else if (by) exp_ptr = m_next(exp_ptr, sep, inc);
        #1 check(req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; load_stb = 0; byte_stb = 0; bank_sep = 1; incr_en = 1; load_addr = 0;
        exp_ptr = 0;
        repeat (3) @(posedge clk);
        #1 check("R1 in reset");
        @(negedge clk); rst = 0;
        @(posedge clk); #1 check("R1 after reset");

        // separated auto-increment: gap skip and wrap (R2 R6)
        tick(1, 8'h09, 0, 1, 1, "R2 load 09");
        tick(0, 0, 1, 1, 1, "R6 step to 0A");
        tick(0, 0, 1, 1, 1, "R6 gap skip to 10");
        tick(1, 8'h1A, 0, 1, 1, "R2 port B last");
        tick(0, 0, 1, 1, 1, "R6 wrap 1A to 00");
        // shared config (R4)
        tick(1, 8'h15, 0, 1, 1, "R4 config B separated");
        tick(1, 8'h0B, 0, 0, 1, "R4 config odd paired");
        tick(0, 0, 0, 1, 1, "R5 0B hole separated, R11 no move");
        tick(1, 8'h0C, 0, 1, 1, "R5 invalid 0C");
        // paired auto-increment (R3 R7)
        tick(1, 8'h14, 0, 0, 1, "R3 load 14");
        tick(0, 0, 1, 0, 1, "R7 step to 15");
        tick(0, 0, 1, 0, 1, "R7 wrap to 00");
        // non-incrementing (R8 R9)
        tick(1, 8'h15, 0, 0, 0, "R9 load odd");
        tick(0, 0, 1, 0, 0, "R9 toggle to 14");
        tick(0, 0, 1, 0, 0, "R9 toggle to 15");
        tick(1, 8'h12, 0, 1, 0, "R8 load 12");
        tick(0, 0, 1, 1, 0, "R8 hold");
        tick(0, 0, 1, 1, 0, "R8 hold again");
        // load priority (R10)
        tick(1, 8'h03, 1, 1, 1, "R10 load beats byte");
        // mode change without strobe, then stepping with new mode (R11)
        tick(0, 0, 0, 0, 0, "R11 mode change idle");
        tick(0, 0, 1, 0, 0, "R11 new mode on step");
        tick(1, 8'h16, 0, 0, 1, "R5 invalid 16 paired");

        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            a = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 8'h1C);
            tick(($urandom % 6) == 0, a, ($urandom % 3) != 0,
                 ($urandom % 8) == 0 ? ~bank_sep : bank_sep,
                 ($urandom % 8) == 0 ? ~incr_en : incr_en,
                 "R2 R3 R5 R6 R7 R8 R9 R10 R11 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule